// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

This block controls a set of general-purpose pins grouped into banks of sixteen. Software reaches it through a single-cycle register port with a valid/ready handshake carrying 32-bit words. For each pin it sets the output value and the output enable, gates and synchronises the pin input, and detects interrupt conditions.

Each pin has three interrupt configuration bits: level-or-edge, any-edge and polarity. These select one of five conditions: high level, low level, rising edge, falling edge or either edge. Edge events are latched until software writes a one to the pin's clear bit. A level condition follows the synchronised input and is not latched. Per-pin enables turn raw status into masked status. The masked bits of every bank are merged onto one interrupt line, and software finds the pin that needs service by reading each bank's masked status.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is low.
- R2: Bank n occupies byte addresses n*0x80 to n*0x80+0x7F. The word offsets are: 0x00 data, 0x04 data mask, 0x08 direction, 0x0C level-sense, 0x10 any-edge, 0x14 polarity, 0x18 interrupt enable, 0x1C raw status (read-only), 0x20 masked status (read-only), 0x24 clear (write-only), 0x28 input enable. Bit k of a register belongs to pin n*16+k, and read bits 31:16 are always 0.
- R3: A request is taken on a rising edge where `bus_valid` is high and `bus_ready` is low. `bus_ready` is then high for exactly one cycle, carrying the read word in `bus_rdata`.
- R4: `pin_oe` of a pin is 1 only when both its direction bit and its data-mask bit are 1. `pin_out` carries the pin's data register bit.
- R5: A data write changes only the bits whose data-mask bit is 1. A data read returns 0 for every bit whose mask bit is 0.
- R6: An input pin (direction 0) with input enable 1 reads its pin value through a two-flop synchroniser. A read accepted on the second edge after a pin change still returns the old value. With input enable 0 the pin reads 0.
- R7: With level-sense 1, raw status is the synchronised gated input when polarity is 1, and its inverse when polarity is 0. It is not latched.
- R8: With level-sense 0 and any-edge 0, a rising edge (polarity 1) or a falling edge (polarity 0) sets a latched raw status bit.
- R9: With level-sense 0 and any-edge 1, every transition of the gated input sets the latched raw status bit.
- R10: Masked status is raw status AND interrupt enable. `irq` is the OR of the masked status bits of all banks.
- R11: Writing 1 to a clear bit removes that pin's latched edge status, and 0 bits leave status unchanged. The clear register reads 0. A level condition that is still present stays in raw status.
- R12: When an edge event and a clear write for the same pin land in the same cycle, the status stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (bank, word offset) |
| bus_wdata | input | 32 | Write word; bits 15:0 used |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read word, valid with `bus_ready` |
| pin_in | input | NUM_BANKS*16 | Pin input levels |
| pin_out | output | NUM_BANKS*16 | Pin output values |
| pin_oe | output | NUM_BANKS*16 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sweeps all five detection modes over both banks using a shared vector sequence of pin patterns and compares raw status, masked status and `irq` against a model it computes itself. If the edge latch were fed from the raw pin instead of the gated and synchronised value, or if any-edge and polarity were decoded in the wrong order, this sweep would show status bits that should not be set. Three cases get targeted checks:
- A clear write lands in the exact cycle an edge becomes visible. A design that lets the clear win loses that interrupt.
- A clear is written while a level condition is still present. A design that latches level status would read 0 afterwards.
- Data is written through a partial mask, and a read is taken one edge too early after a pin change. A design that ignores the mask corrupts bits it must not touch, and a design with one synchroniser stage too few shows the new value too soon.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PINS_PER_BANK = 16;
  localparam int BANK_SPAN_LG2 = 7;
  localparam int SEL_W         = 5;

  // word index inside a bank window (byte offset / 4)
  localparam logic [SEL_W-1:0] SEL_OUTV  = 5'd0;
  localparam logic [SEL_W-1:0] SEL_GATE  = 5'd1;
  localparam logic [SEL_W-1:0] SEL_DRIVE = 5'd2;
  localparam logic [SEL_W-1:0] SEL_LVL   = 5'd3;
  localparam logic [SEL_W-1:0] SEL_ANY   = 5'd4;
  localparam logic [SEL_W-1:0] SEL_POL   = 5'd5;
  localparam logic [SEL_W-1:0] SEL_IEN   = 5'd6;
  localparam logic [SEL_W-1:0] SEL_RAW   = 5'd7;
  localparam logic [SEL_W-1:0] SEL_MSK   = 5'd8;
  localparam logic [SEL_W-1:0] SEL_ACK   = 5'd9;
  localparam logic [SEL_W-1:0] SEL_INEN  = 5'd10;

  typedef logic [PINS_PER_BANK-1:0] bank_vec_t;

  // Per-pin edge events for the configured edge kind.
  function automatic bank_vec_t edge_events(bank_vec_t cur, bank_vec_t prev,
                                            bank_vec_t any, bank_vec_t pol);
    bank_vec_t rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    return (any & (rise | fall)) | (~any & pol & rise) | (~any & ~pol & fall);
  endfunction

  // Level hits: active when the enabled input equals the polarity.
  function automatic bank_vec_t level_hits(bank_vec_t en, bank_vec_t lvl,
                                           bank_vec_t pol);
    return en & ~(lvl ^ pol);
  endfunction

  // Masked merge of a write into a register.
  function automatic bank_vec_t merge_write(bank_vec_t old, bank_vec_t nv,
                                            bank_vec_t keep_mask);
    return (old & ~keep_mask) | (nv & keep_mask);
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bank_vec_t sampled,
  input  bank_vec_t usable,
  input  bank_vec_t lvl_mode,
  input  bank_vec_t any_edge,
  input  bank_vec_t pol,
  input  logic      ack_we,
  input  bank_vec_t ack_bits,
  output bank_vec_t edge_now,
  output bank_vec_t edge_held,
  output bank_vec_t raw
);
  bank_vec_t prev_q;
  bank_vec_t ack_mask;

  assign edge_now = edge_events(sampled, prev_q, any_edge, pol) & ~lvl_mode;
  assign ack_mask = ack_we ? ack_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      edge_held <= '0;
    end else begin
      prev_q    <= sampled;
      // a fresh event outranks a simultaneous acknowledge
      edge_held <= (edge_held & ~ack_mask) | edge_now;
    end
  end

  assign raw = (lvl_mode & level_hits(usable, sampled, pol)) | (~lvl_mode & edge_held);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  input  bank_vec_t        wr_data,
  input  bank_vec_t        pad_in,
  output bank_vec_t        rd_data,
  output bank_vec_t        pad_out,
  output bank_vec_t        pad_oe,
  output bank_vec_t        stat_masked,
  output bank_vec_t        irq_en,
  output bank_vec_t        edge_held,
  output logic             ack_hit
);
  bank_vec_t outv_q, gate_q, drive_q, lvl_q, any_q, pol_q, ien_q, inen_q;
  bank_vec_t pad_sync, sampled, usable, stat_raw, edge_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outv_q  <= '0;
      gate_q  <= '0;
      drive_q <= '0;
      lvl_q   <= '0;
      any_q   <= '0;
      pol_q   <= '0;
      ien_q   <= '0;
      inen_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_OUTV:  outv_q  <= merge_write(outv_q, wr_data, gate_q);
        SEL_GATE:  gate_q  <= wr_data;
        SEL_DRIVE: drive_q <= wr_data;
        SEL_LVL:   lvl_q   <= wr_data;
        SEL_ANY:   any_q   <= wr_data;
        SEL_POL:   pol_q   <= wr_data;
        SEL_IEN:   ien_q   <= wr_data;
        SEL_INEN:  inen_q  <= wr_data;
        default:   ;
      endcase
    end
  end

  gpio_sync2 #(.W(PINS_PER_BANK)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  assign usable  = inen_q & ~drive_q;
  assign sampled = pad_sync & usable;
  assign ack_hit = wr_en && (sel == SEL_ACK);

  gpio_irq_detect det_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sampled   (sampled),
    .usable    (usable),
    .lvl_mode  (lvl_q),
    .any_edge  (any_q),
    .pol       (pol_q),
    .ack_we    (ack_hit),
    .ack_bits  (wr_data),
    .edge_now  (edge_now),
    .edge_held (edge_held),
    .raw       (stat_raw)
  );

  assign stat_masked = stat_raw & ien_q;
  assign irq_en      = ien_q;
  assign pad_out     = outv_q;
  assign pad_oe      = drive_q & gate_q;

  always_comb begin
    case (sel)
      SEL_OUTV:  rd_data = gate_q & ((drive_q & outv_q) | (~drive_q & sampled));
      SEL_GATE:  rd_data = gate_q;
      SEL_DRIVE: rd_data = drive_q;
      SEL_LVL:   rd_data = lvl_q;
      SEL_ANY:   rd_data = any_q;
      SEL_POL:   rd_data = pol_q;
      SEL_IEN:   rd_data = ien_q;
      SEL_RAW:   rd_data = stat_raw;
      SEL_MSK:   rd_data = stat_masked;
      SEL_INEN:  rd_data = inen_q;
      default:   rd_data = '0;
    endcase
  end

  logic unused_evt;
  assign unused_evt = ^edge_now;
endmodule

// File: rtl/banked_gpio_ctrl.sv
module banked_gpio_ctrl
  import gpio_bank_pkg::*;
#(
  parameter  int NUM_BANKS = 2,
  localparam int NPINS     = NUM_BANKS * PINS_PER_BANK,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W    = BANK_SPAN_LG2 + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic              accept;
  logic [BANK_W-1:0] bank_idx;
  logic [SEL_W-1:0]  sel;
  bank_vec_t         rd_words [NUM_BANKS];
  bank_vec_t         rd_word;
  logic [NUM_BANKS-1:0] ack_hits;
  logic [NPINS-1:0]  all_masked, all_ien, all_edge_held;
  logic              ack_any;

  assign accept   = bus_valid && !bus_ready;
  assign bank_idx = bus_addr[ADDR_W-1:BANK_SPAN_LG2];
  assign sel      = bus_addr[BANK_SPAN_LG2-1:2];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * PINS_PER_BANK;
    logic bank_wr;
    assign bank_wr = accept && bus_write && (bank_idx == BANK_W'(b));

    gpio_bank bank_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (bank_wr),
      .sel         (sel),
      .wr_data     (bus_wdata[PINS_PER_BANK-1:0]),
      .pad_in      (pin_in[LO +: PINS_PER_BANK]),
      .rd_data     (rd_words[b]),
      .pad_out     (pin_out[LO +: PINS_PER_BANK]),
      .pad_oe      (pin_oe[LO +: PINS_PER_BANK]),
      .stat_masked (all_masked[LO +: PINS_PER_BANK]),
      .irq_en      (all_ien[LO +: PINS_PER_BANK]),
      .edge_held   (all_edge_held[LO +: PINS_PER_BANK]),
      .ack_hit     (ack_hits[b])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_idx == BANK_W'(b)) rd_word = rd_words[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= accept;
      if (accept) bus_rdata <= bus_write ? 32'd0 : {16'd0, rd_word};
    end
  end

  assign ack_any = |ack_hits;
  assign irq     = |all_masked;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:PINS_PER_BANK], bus_addr[1:0]};
endmodule

// File: rtl/gpio_ctrl_checker.sv
module gpio_ctrl_checker
  import gpio_bank_pkg::*;
#(
  parameter  int NUM_BANKS = 2,
  localparam int NPINS     = NUM_BANKS * PINS_PER_BANK,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W    = BANK_SPAN_LG2 + BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ready,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic [NPINS-1:0]  all_ien,
  input logic [NPINS-1:0]  all_edge_held,
  input logic              ack_any
);
  a_r3_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  a_r3_ready_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> $past(bus_valid));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> (bus_rdata[31:16] == 16'd0));

  a_r11_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && $past(!bus_write && bus_addr[BANK_SPAN_LG2-1:2] == SEL_ACK))
      |-> (bus_rdata == 32'd0));

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (all_ien == '0) |-> !irq);

  a_r11_drop_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(all_edge_held) & ~all_edge_held) != '0) |-> $past(ack_any));
endmodule

bind banked_gpio_ctrl gpio_ctrl_checker #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_valid     (bus_valid),
  .bus_write     (bus_write),
  .bus_addr      (bus_addr),
  .bus_ready     (bus_ready),
  .bus_rdata     (bus_rdata),
  .irq           (irq),
  .all_ien       (all_ien),
  .all_edge_held (all_edge_held),
  .ack_any       (ack_any)
);

// File: tb/banked_gpio_ctrl_tb_top.sv
`timescale 1ns/1ps
module banked_gpio_ctrl_tb_top;
  localparam int NB = 2;
  localparam int NP = NB * 16;
  localparam int AW = 8;
  localparam int O_DATA = 0, O_MASK = 1, O_DIR = 2, O_LVL = 3, O_ANY = 4,
                 O_POL = 5, O_IEN = 6, O_RAW = 7, O_MSK = 8, O_CLR = 9, O_INEN = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, irq;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  int n_checks = 0, n_err = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  banked_gpio_ctrl #(.NUM_BANKS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input int bank, input int off,
                      input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr;
    bus_addr  = AW'(bank * 128 + off * 4); bus_wdata = wd;
    do @(negedge clk); while (!bus_ready);
    rd = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic wr(input int bank, input int off, input logic [31:0] wd);
    logic [31:0] d;
    xfer(1'b1, bank, off, wd, d);
  endtask

  task automatic rd(input int bank, input int off, output logic [31:0] d);
    xfer(1'b0, bank, off, 32'd0, d);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] vec(input int k);
    case (k)
      0: return 16'h00FF;
      1: return 16'hF0F0;
      2: return 16'hFFFF;
      3: return 16'h1234;
      4: return 16'h8001;
      default: return 16'h0000;
    endcase
  endfunction

  // mode m -> {level-sense, any-edge, polarity}
  function automatic logic [2:0] mode_bits(input int m);
    case (m)
      0: return 3'b101;
      1: return 3'b100;
      2: return 3'b001;
      3: return 3'b000;
      default: return 3'b010;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values of every register, pins and irq
    check("R1 pin_oe", 32'(pin_oe), 32'd0);
    check("R1 pin_out", 32'(pin_out), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    for (int b = 0; b < NB; b++)
      for (int o = 0; o <= O_INEN; o++) begin
        rd(b, o, rv);
        check($sformatf("R1 reset bank%0d off%0d", b, o), rv, 32'd0);
      end

    // R2: readback of writable registers, bank isolation, upper bits zero
    for (int b = 0; b < NB; b++)
      for (int o = O_MASK; o <= O_INEN; o++)
        if (o != O_RAW && o != O_MSK && o != O_CLR)
          wr(b, o, {16'hBEEF, 16'((o * 16'h1357) ^ (b * 16'h2468) ^ 16'h0F0F)});
    for (int b = 0; b < NB; b++)
      for (int o = O_MASK; o <= O_INEN; o++)
        if (o != O_RAW && o != O_MSK && o != O_CLR) begin
          rd(b, o, rv);
          check($sformatf("R2 readback bank%0d off%0d", b, o), rv,
                {16'd0, 16'((o * 16'h1357) ^ (b * 16'h2468) ^ 16'h0F0F)});
        end
    for (int b = 0; b < NB; b++) begin
      for (int o = O_MASK; o <= O_INEN; o++)
        if (o != O_RAW && o != O_MSK && o != O_CLR) wr(b, o, 32'd0);
      wr(b, O_CLR, 32'hFFFF);
      wr(b, O_RAW, 32'hFFFF);
      rd(b, O_RAW, rv);
      check("R2 raw status read-only", rv, 32'd0);
      rd(b, O_CLR, rv);
      check("R11 clear reads zero", rv, 32'd0);
    end

    // R4/R5: output path through a partial data mask (bank 0)
    wr(0, O_DIR, 32'hFFFF);
    wr(0, O_MASK, 32'h00FF);
    wr(0, O_DATA, 32'hFFFF);
    rd(0, O_DATA, rv);
    check("R5 masked write", rv, 32'h00FF);
    check("R4 pin_out", 32'(pin_out[15:0]), 32'h00FF);
    check("R4 pin_oe needs mask", 32'(pin_oe[15:0]), 32'h00FF);
    wr(0, O_MASK, 32'hFFFF);
    rd(0, O_DATA, rv);
    check("R5 unmasked bits untouched", rv, 32'h00FF);
    check("R4 pin_oe full", 32'(pin_oe[15:0]), 32'hFFFF);
    wr(0, O_DATA, 32'hA5A5);
    rd(0, O_DATA, rv);
    check("R5 full write", rv, 32'hA5A5);
    check("R4 pin_out pattern", 32'(pin_out[15:0]), 32'hA5A5);
    wr(0, O_MASK, 32'h0000);
    rd(0, O_DATA, rv);
    check("R5 mask 0 reads 0", rv, 32'd0);
    check("R4 pin_oe off", 32'(pin_oe[15:0]), 32'd0);
    wr(0, O_DIR, 32'h0000);

    // R6: input path, synchroniser latency, input enable (bank 1)
    wr(1, O_MASK, 32'hFFFF);
    wr(1, O_INEN, 32'h0F0F);
    settle();
    pin_in[31:16] = 16'h3C3C;
    rd(1, O_DATA, rv);
    check("R6 two-flop latency", rv, 32'd0);
    rd(1, O_DATA, rv);
    check("R6 gated input", rv, 32'h0C0C);
    wr(1, O_MASK, 32'h00FF);
    rd(1, O_DATA, rv);
    check("R5 input read masked", rv, 32'h000C);
    pin_in = '0;
    settle();
    wr(1, O_INEN, 32'h0);
    wr(1, O_CLR, 32'hFFFF);

    // R7..R11: every mode on every bank over a vector sequence
    for (int b = 0; b < NB; b++)
      for (int m = 0; m < 5; m++) begin
        logic [2:0]  mb;
        logic [15:0] ien, prev, held, v, ev, raw_e;
        mb  = mode_bits(m);
        ien = (b == 0) ? 16'h5A5A : 16'hC3A5;
        wr(b, O_MASK, 32'hFFFF);
        wr(b, O_INEN, 32'hFFFF);
        wr(b, O_LVL, {16'd0, {16{mb[2]}}});
        wr(b, O_ANY, {16'd0, {16{mb[1]}}});
        wr(b, O_POL, {16'd0, {16{mb[0]}}});
        wr(b, O_IEN, {16'd0, ien});
        wr(b, O_CLR, 32'hFFFF);
        prev = '0; held = '0;
        for (int k = 0; k < 6; k++) begin
          v = vec(k);
          pin_in[b*16 +: 16] = v;
          settle();
          ev = mb[1] ? (v ^ prev) : (mb[0] ? (v & ~prev) : (~v & prev));
          held = held | ev;
          prev = v;
          raw_e = mb[2] ? (mb[0] ? v : ~v) : held;
          rd(b, O_RAW, rv);
          check($sformatf("R7/R8/R9 raw bank%0d mode%0d step%0d", b, m, k), rv, {16'd0, raw_e});
          rd(b, O_MSK, rv);
          check($sformatf("R10 masked bank%0d mode%0d step%0d", b, m, k), rv, {16'd0, raw_e & ien});
          check($sformatf("R10 irq bank%0d mode%0d step%0d", b, m, k), 32'(irq), 32'(|(raw_e & ien)));
        end
        wr(b, O_CLR, 32'h0);
        rd(b, O_RAW, rv);
        check($sformatf("R11 zero clear bank%0d mode%0d", b, m), rv, {16'd0, raw_e});
        wr(b, O_CLR, 32'hFFFF);
        rd(b, O_RAW, rv);
        check($sformatf("R11 clear bank%0d mode%0d", b, m), rv,
              {16'd0, mb[2] ? (mb[0] ? v : ~v) : 16'h0000});
        wr(b, O_IEN, 32'h0);
        pin_in = '0;
        settle();
        wr(b, O_INEN, 32'h0);
        wr(b, O_LVL, 32'h0);
        wr(b, O_ANY, 32'h0);
        wr(b, O_POL, 32'h0);
        wr(b, O_CLR, 32'hFFFF);
      end

    // R12: an edge becoming visible in the same cycle as its clear
    wr(0, O_INEN, 32'hFFFF);
    wr(0, O_POL, 32'hFFFF);
    wr(0, O_IEN, 32'h0001);
    wr(0, O_CLR, 32'hFFFF);
    settle();
    @(negedge clk);
    pin_in[0] = 1'b1;
    @(negedge clk);
    wr(0, O_CLR, 32'h0001);
    rd(0, O_RAW, rv);
    check("R12 edge beats clear", rv, 32'h0001);
    check("R12 irq stays", 32'(irq), 32'd1);
    wr(0, O_CLR, 32'h0001);
    rd(0, O_RAW, rv);
    check("R11 later clear", rv, 32'd0);
    check("R10 irq drops", 32'(irq), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule